// File: doc/BRIEF.md
# Voice Trigger Input Controller

This block sits between five active-high key inputs and a sentence playback engine. Each raw key level is synchronised and debounced on a sample-rate tick. A per-key configuration then decides when a sentence starts, restarts, repeats or stops. The key set is one single key plus four column keys. The configuration selects level or edge start, hold or unhold release behaviour, retrigger or irretrigger on a new press, fast or slow debounce, and looping. A further per-key bit lets the engine's busy state push that key into slow debounce and retrigger behaviour.

When several keys are accepted in the same cycle, the highest-numbered column key wins. A configuration bit decides whether a later press on another key takes over a running sentence or is ignored. The engine reports busy and a one-cycle end-of-sentence pulse. The block answers with a one-cycle play request carrying a 5-bit sentence index, or with a one-cycle stop request. The single key can also walk through the sentence list in four ways: a fixed entry, all sentences in order, the next sentence on each press, or a pseudo-random pick.

Top module: `vtrig_ctrl`

## Requirements
- R1: A raw key level is accepted only after it has differed from the accepted level on consecutive sample ticks: 1 tick in fast mode, 96 ticks in slow mode. A slow-mode pulse shorter than 96 ticks produces no playback.
- R2: With bit 0 of a key's 6-bit field `key_cfg[k*6 +: 6]` set (edge start), each accepted rising edge gives exactly one play request for the key's slot `sent_map[k*5 +: 5]`. This holds whether the key is released early or held past the end of the sentence.
- R3: With bit 0 clear (level start), the sentence is requested again at each end-of-sentence while the key is still high. After release, the running sentence ends and no further request follows.
- R4: With bit 1 set (hold), an accepted release of the owning key produces one stop request and no further play request. With bit 1 clear, a release produces no stop request.
- R5: With bit 2 set (retrigger), an accepted rising edge of the owning key during playback issues a new play request. With bit 2 clear, such an edge is ignored.
- R6: Keys accepted in the same cycle are ranked by `key_raw` bit: bit 4 (column 3) > bit 3 > bit 2 > bit 1 > bit 0 (single key). Only the winner is played.
- R7: With `last_key_pri` = 1, a rising edge of a different key during playback takes over with that key's sentence. With 0, it is ignored.
- R8: With bit 5 of a key's field clear, the key uses slow debounce and retrigger while `eng_busy` is high, and its configured bits while low. With bit 5 set, busy has no effect.
- R9: With bit 4 set (loop), the sentence is requested again at every end-of-sentence. In hold mode the loop ends with a stop request at release.
- R10: `sel_mode` selects the single key's sentence: 0 = slot 0 of `sent_map`, 1 = play-all, 2 = play-next, 3 = random. `sent_count` (valid 1..32) is the sentence count for modes 1 to 3.
- R11: Play-next issues 0, 1, … , `sent_count`-1 on successive presses after reset, then wraps to 0.
- R12: Play-all issues sentences 0 up to `sent_count`-1 back to back from one press, each after the previous end-of-sentence, then stops.
- R13: Random mode issues `s mod sent_count`, where `s` is an 8-bit state. The state is 1 after reset and steps on each press to `{s[6:0], s[7]^s[5]^s[4]^s[3]}`.
- R14: During and after reset both requests are low until a key is accepted. A play request and a stop request never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle sample-rate tick driving the debounce counters |
| key_raw | input | 5 | Raw key levels, bit 0 single key, bits 1..4 column keys 0..3 |
| key_cfg | input | 30 | Six configuration bits per key |
| sent_map | input | 25 | Five-bit sentence slot per key |
| sel_mode | input | 2 | Single-key selection mode |
| sent_count | input | 6 | Number of sentences for the list modes |
| last_key_pri | input | 1 | 1 = a new key takes over, 0 = first key keeps playing |
| eng_busy | input | 1 | Playback engine is busy |
| eng_done | input | 1 | One-cycle end-of-sentence pulse |
| play_req | output | 1 | One-cycle request to start a sentence |
| play_idx | output | 5 | Sentence index, valid with play_req |
| stop_req | output | 1 | One-cycle request to stop playback |

## Verification
The bench sweeps every sentence count from 1 to 32 in play-next and random modes. An off-by-one wrap or a wrong modulo would show up as a wrong index at the count boundary. It times slow-debounce pulses just short of and well past 96 ticks, so a counter that accepts early or never accepts fails. Busy-dependent forcing is tested both ways: a design that ignored busy would either accept a short press or refuse a retrigger during playback. Hold against unhold, level repeat, looping and both priority schemes are each checked by counting play and stop requests after the sentence end that matters.

// File: rtl/vtrig_pkg.sv
package vtrig_pkg;

    localparam int NUM_KEYS   = 5;
    localparam int CFG_W      = 6;
    localparam int SENT_W     = 5;
    localparam int MAX_SENT   = 32;
    localparam int CNT_W      = 6;
    localparam int LFSR_W     = 8;
    localparam int FAST_TICKS = 1;
    localparam int SLOW_TICKS = 96;

    typedef struct packed {
        logic keep_fast;
        logic loop_en;
        logic slow_db;
        logic retrig;
        logic hold;
        logic edge_m;
    } key_cfg_t;

    typedef enum logic [1:0] {
        SEL_FIXED = 2'd0,
        SEL_ALL   = 2'd1,
        SEL_NEXT  = 2'd2,
        SEL_RAND  = 2'd3
    } sel_mode_e;

    // Busy forces slow debounce and retrigger on keys that allow it.
    function automatic key_cfg_t apply_force(key_cfg_t c, logic busy);
        key_cfg_t r;
        r = c;
        if (!c.keep_fast && busy) begin
            r.slow_db = 1'b1;
            r.retrig  = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] count_floor(logic [CNT_W-1:0] n);
        if (n == '0)
            return CNT_W'(1);
        else if (n > CNT_W'(MAX_SENT))
            return CNT_W'(MAX_SENT);
        else
            return n;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/vtrig_debounce.sv
module vtrig_debounce #(
    parameter int FAST_TICKS = 1,
    parameter int SLOW_TICKS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    input  logic slow_sel,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(SLOW_TICKS + 1);

    logic          sync1_q, sync2_q;
    logic          lvl_q, lvl_d_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] run_inc;
    logic [CW-1:0] limit;

    assign run_inc = run_q + 1'b1;
    assign limit   = slow_sel ? CW'(SLOW_TICKS) : CW'(FAST_TICKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            lvl_q   <= 1'b0;
            lvl_d_q <= 1'b0;
            run_q   <= '0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
            lvl_d_q <= lvl_q;
            if (tick) begin
                if (sync2_q != lvl_q) begin
                    if (run_inc >= limit) begin
                        lvl_q <= sync2_q;
                        run_q <= '0;
                    end else begin
                        run_q <= run_inc;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    assign lvl  = lvl_q;
    assign rise = lvl_q & ~lvl_d_q;
    assign fall = ~lvl_q & lvl_d_q;

endmodule

// File: rtl/vtrig_prio.sv
module vtrig_prio #(
    parameter int N = 5,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // Highest set bit wins.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vtrig_keysel.sv
module vtrig_keysel
    import vtrig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sel_mode_e         mode,
    input  logic [CNT_W-1:0]  count,
    input  logic [SENT_W-1:0] fixed_idx,
    input  logic              adv,
    output logic [SENT_W-1:0] sel_idx
);
    logic [SENT_W-1:0] nxt_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic [CNT_W-1:0]  n_eff;
    logic [CNT_W-1:0]  nxt_wide;
    logic [CNT_W-1:0]  nxt_p1;
    logic [LFSR_W-1:0] rem;
    logic [SENT_W-1:0] nxt_use;

    assign n_eff    = count_floor(count);
    assign nxt_wide = CNT_W'(nxt_q);
    assign nxt_use  = (nxt_wide >= n_eff) ? '0 : nxt_q;
    assign nxt_p1   = CNT_W'(nxt_use) + 1'b1;
    assign rem      = lfsr_q % LFSR_W'(n_eff);

    always_comb begin
        unique case (mode)
            SEL_FIXED: sel_idx = fixed_idx;
            SEL_ALL:   sel_idx = '0;
            SEL_NEXT:  sel_idx = nxt_use;
            SEL_RAND:  sel_idx = SENT_W'(rem);
            default:   sel_idx = fixed_idx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q  <= '0;
            lfsr_q <= LFSR_W'(1);
        end else if (adv) begin
            if (mode == SEL_NEXT)
                nxt_q <= (nxt_p1 >= n_eff) ? '0 : SENT_W'(nxt_p1);
            if (mode == SEL_RAND)
                lfsr_q <= lfsr_step(lfsr_q);
        end
    end

endmodule

// File: rtl/vtrig_ctrl.sv
module vtrig_ctrl
    import vtrig_pkg::*;
#(
    parameter int KEYS     = NUM_KEYS,
    parameter int FAST_CNT = FAST_TICKS,
    parameter int SLOW_CNT = SLOW_TICKS,
    localparam int IW      = $clog2(KEYS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_tick,
    input  logic [KEYS-1:0]          key_raw,
    input  logic [KEYS*CFG_W-1:0]    key_cfg,
    input  logic [KEYS*SENT_W-1:0]   sent_map,
    input  logic [1:0]               sel_mode,
    input  logic [CNT_W-1:0]         sent_count,
    input  logic                     last_key_pri,
    input  logic                     eng_busy,
    input  logic                     eng_done,
    output logic                     play_req,
    output logic [SENT_W-1:0]        play_idx,
    output logic                     stop_req
);
    key_cfg_t          cfg_a [KEYS];
    key_cfg_t          eff_a [KEYS];
    logic [SENT_W-1:0] map_a [KEYS];
    logic [KEYS-1:0]   lvl, rise, fall, cand;

    logic              act_q, act_n;
    logic [IW-1:0]     own_q, own_n;
    logic [SENT_W-1:0] cur_q, cur_n;
    logic              play_q, play_n;
    logic              stop_q, stop_n;

    logic              win_vld;
    logic [IW-1:0]     win_idx;
    logic [SENT_W-1:0] key_idx;
    sel_mode_e         mode;

    assign mode = sel_mode_e'(sel_mode);

    for (genvar g = 0; g < KEYS; g++) begin : g_key
        assign cfg_a[g] = key_cfg_t'(key_cfg[g*CFG_W +: CFG_W]);
        assign eff_a[g] = apply_force(cfg_a[g], eng_busy);
        assign map_a[g] = sent_map[g*SENT_W +: SENT_W];

        vtrig_debounce #(
            .FAST_TICKS (FAST_CNT),
            .SLOW_TICKS (SLOW_CNT)
        ) u_db (
            .clk      (clk),
            .rst      (rst),
            .tick     (smp_tick),
            .raw      (key_raw[g]),
            .slow_sel (eff_a[g].slow_db),
            .lvl      (lvl[g]),
            .rise     (rise[g]),
            .fall     (fall[g])
        );

        // Own key restarts only when retriggering; others only under last-key priority.
        assign cand[g] = rise[g] &
                         (~act_q | ((IW'(g) == own_q) ? eff_a[g].retrig : last_key_pri));
    end

    vtrig_prio #(.N(KEYS)) u_prio (
        .req (cand),
        .vld (win_vld),
        .idx (win_idx)
    );

    vtrig_keysel u_sel (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .count     (sent_count),
        .fixed_idx (map_a[0]),
        .adv       (win_vld && (win_idx == '0)),
        .sel_idx   (key_idx)
    );

    key_cfg_t          own_cfg;
    logic              own_lvl, own_fall, is_all;
    logic [CNT_W-1:0]  n_eff, cur_p1;
    logic [SENT_W-1:0] rep_idx;

    assign own_cfg  = cfg_a[own_q];
    assign own_lvl  = lvl[own_q];
    assign own_fall = fall[own_q];
    assign n_eff    = count_floor(sent_count);
    assign cur_p1   = CNT_W'(cur_q) + 1'b1;
    assign is_all   = (own_q == '0) && (mode == SEL_ALL);
    assign rep_idx  = is_all ? '0 : cur_q;

    always_comb begin
        act_n  = act_q;
        own_n  = own_q;
        cur_n  = cur_q;
        play_n = 1'b0;
        stop_n = 1'b0;
        if (win_vld) begin
            act_n  = 1'b1;
            own_n  = win_idx;
            cur_n  = (win_idx == '0) ? key_idx : map_a[win_idx];
            play_n = 1'b1;
        end else if (act_q && own_fall && own_cfg.hold) begin
            act_n  = 1'b0;
            stop_n = 1'b1;
        end else if (act_q && eng_done) begin
            if (is_all && (cur_p1 < n_eff)) begin
                cur_n  = SENT_W'(cur_p1);
                play_n = 1'b1;
            end else if (own_cfg.loop_en && !(own_cfg.hold && !own_lvl)) begin
                cur_n  = rep_idx;
                play_n = 1'b1;
            end else if (!own_cfg.edge_m && own_lvl) begin
                cur_n  = rep_idx;
                play_n = 1'b1;
            end else begin
                act_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            own_q  <= '0;
            cur_q  <= '0;
            play_q <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            act_q  <= act_n;
            own_q  <= own_n;
            cur_q  <= cur_n;
            play_q <= play_n;
            stop_q <= stop_n;
        end
    end

    assign play_req = play_q;
    assign play_idx = cur_q;
    assign stop_req = stop_q;

endmodule

// File: rtl/vtrig_ctrl_chk.sv
module vtrig_ctrl_chk
    import vtrig_pkg::*;
#(
    parameter int KEYS = NUM_KEYS,
    localparam int IW  = $clog2(KEYS)
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_tick,
    input logic              play_req,
    input logic              stop_req,
    input logic [SENT_W-1:0] play_idx,
    input logic [1:0]        sel_mode,
    input logic [CNT_W-1:0]  sent_count,
    input logic [KEYS-1:0]   lvl,
    input logic              act_q,
    input logic [IW-1:0]     own_q
);
    AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> $past(smp_tick)); // R1

    AST_PLAY_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(play_req && stop_req)); // R14

    AST_STOP_FROM_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> ($past(act_q) && !act_q)); // R4

    AST_PLAY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        play_req |-> act_q); // R2

    AST_KEY_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (play_req && (own_q == '0) && (sel_mode != 2'd0))
            |-> (CNT_W'(play_idx) < count_floor(sent_count))); // R11

endmodule

bind vtrig_ctrl vtrig_ctrl_chk #(.KEYS(KEYS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_tick   (smp_tick),
    .play_req   (play_req),
    .stop_req   (stop_req),
    .play_idx   (play_idx),
    .sel_mode   (sel_mode),
    .sent_count (sent_count),
    .lvl        (lvl),
    .act_q      (act_q),
    .own_q      (own_q)
);

// File: tb/sim_vtrig_ctrl.sv
`timescale 1ns/1ps
module sim_vtrig_ctrl;
    import vtrig_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_tick = 1'b0;
    logic [4:0]  key_raw = '0;
    logic [29:0] key_cfg = '0;
    logic [24:0] sent_map = '0;
    logic [1:0]  sel_mode = '0;
    logic [5:0]  sent_count = 6'd1;
    logic        last_key_pri = 1'b0;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        play_req, stop_req;
    logic [4:0]  play_idx;

    always #10 clk = ~clk;

    vtrig_ctrl u0 (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .key_raw(key_raw),
        .key_cfg(key_cfg), .sent_map(sent_map), .sel_mode(sel_mode),
        .sent_count(sent_count), .last_key_pri(last_key_pri),
        .eng_busy(eng_busy), .eng_done(eng_done),
        .play_req(play_req), .play_idx(play_idx), .stop_req(stop_req)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int nplay = 0, nstop = 0, eng_len = 100, ecnt = 0;
    int hist [0:127];
    logic [1:0] tdiv = '0;

    always @(negedge clk) begin
        tdiv = tdiv + 2'd1;
        smp_tick = (tdiv == 2'd3);
    end

    // Playback engine model
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (rst) begin
            eng_busy = 1'b0;
            ecnt = 0;
        end else if (play_req) begin
            eng_busy = 1'b1;
            ecnt = eng_len;
        end else if (stop_req) begin
            eng_busy = 1'b0;
        end else if (eng_busy) begin
            if (ecnt <= 1) begin
                eng_busy = 1'b0;
                eng_done = 1'b1;
            end else begin
                ecnt = ecnt - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (play_req) begin
                if (nplay < 128) hist[nplay] = int'(play_idx);
                nplay++;
            end
            if (stop_req) nstop++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] mk(bit edge_m, bit hold, bit retrig, bit slow, bit loop_en, bit keep);
        return {keep, loop_en, slow, retrig, hold, edge_m};
    endfunction

    task automatic set_cfg(input int k, input logic [5:0] c);
        key_cfg[k*6 +: 6] = c;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int k, input int n);
        @(negedge clk);
        key_raw[k] = 1'b1;
        repeat (n) @(negedge clk);
        key_raw[k] = 1'b0;
    endtask

    task automatic start_test(input int len, input logic [1:0] mode, input int cnt, input bit lk);
        @(negedge clk);
        rst = 1'b1;
        key_raw = '0;
        eng_len = len;
        sel_mode = mode;
        sent_count = 6'(cnt);
        last_key_pri = lk;
        for (int k = 0; k < 5; k++) begin
            set_cfg(k, mk(1, 0, 0, 0, 0, 1));
            sent_map[k*5 +: 5] = 5'(k * 5 + 3);
        end
        idle(4);
        rst = 1'b0;
        nplay = 0;
        nstop = 0;
    endtask

    function automatic logic [7:0] lstep(logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    initial begin
        int snap;
        logic [7:0] l;

        // Reset
        start_test(100, 2'd0, 1, 0);
        rst = 1'b1;
        idle(2);
        chk(!play_req && !stop_req, "R14 reset outputs", int'(play_req) + int'(stop_req), 0);
        rst = 1'b0;
        idle(200);
        chk(nplay == 0 && nstop == 0, "R14 idle after reset", nplay + nstop, 0);

        // Edge, unhold: early release and held past end
        start_test(200, 2'd0, 1, 0);
        press(1, 20);
        idle(400);
        chk(nplay == 1, "R2 edge early release plays", nplay, 1);
        chk(hist[0] == 8, "R2 edge slot index", hist[0], 8);
        chk(nstop == 0, "R4 unhold no stop", nstop, 0);
        press(1, 1000);
        idle(400);
        chk(nplay == 2, "R2 edge held past end", nplay, 2);

        // Level mode
        start_test(200, 2'd0, 1, 0);
        set_cfg(1, mk(0, 0, 0, 0, 0, 1));
        press(1, 500);
        idle(600);
        chk(nplay == 3, "R3 level repeats while high", nplay, 3);

        // Hold mode
        start_test(200, 2'd0, 1, 0);
        set_cfg(2, mk(1, 1, 0, 0, 0, 1));
        press(2, 50);
        idle(400);
        chk(nplay == 1, "R4 hold play count", nplay, 1);
        chk(nstop == 1, "R4 hold stop on release", nstop, 1);

        // Retrigger vs irretrigger
        start_test(300, 2'd0, 1, 0);
        set_cfg(3, mk(1, 0, 1, 0, 0, 1));
        press(3, 20); idle(40); press(3, 20);
        idle(500);
        chk(nplay == 2, "R5 retrigger restarts", nplay, 2);
        chk(hist[1] == 18, "R5 retrigger index", hist[1], 18);
        start_test(300, 2'd0, 1, 0);
        press(1, 20); idle(40); press(1, 20);
        idle(500);
        chk(nplay == 1, "R5 irretrigger ignores", nplay, 1);

        // Simultaneous priority
        start_test(100, 2'd0, 1, 0);
        @(negedge clk); key_raw = 5'b11111; idle(20); key_raw = '0;
        idle(300);
        chk(nplay == 1 && hist[0] == 23, "R6 all keys col3 wins", hist[0], 23);
        start_test(100, 2'd0, 1, 0);
        @(negedge clk); key_raw = 5'b00101; idle(20); key_raw = '0;
        idle(300);
        chk(nplay == 1 && hist[0] == 13, "R6 col1 over single key", hist[0], 13);

        // First-key vs last-key
        start_test(300, 2'd0, 1, 0);
        press(1, 20); idle(40); press(4, 20);
        idle(500);
        chk(nplay == 1 && hist[0] == 8, "R7 first-key ignores other", nplay, 1);
        start_test(300, 2'd0, 1, 1);
        press(1, 20); idle(40); press(4, 20);
        idle(500);
        chk(nplay == 2, "R7 last-key takes over", nplay, 2);
        chk(hist[1] == 23, "R7 last-key index", hist[1], 23);

        // Slow debounce
        start_test(100, 2'd0, 1, 0);
        set_cfg(2, mk(1, 0, 0, 1, 0, 1));
        press(2, 320);
        idle(600);
        chk(nplay == 0, "R1 slow short pulse rejected", nplay, 0);
        press(2, 480);
        idle(600);
        chk(nplay == 1, "R1 slow long pulse accepted", nplay, 1);
        start_test(100, 2'd0, 1, 0);
        press(2, 6);
        idle(300);
        chk(nplay == 1, "R1 fast short pulse accepted", nplay, 1);

        // Busy forcing
        start_test(2000, 2'd0, 1, 0);
        set_cfg(1, mk(1, 0, 0, 0, 0, 0));
        press(1, 20);
        idle(100);
        chk(nplay == 1, "R8 idle uses fast debounce", nplay, 1);
        press(1, 40);
        idle(500);
        chk(nplay == 1, "R8 busy forces slow debounce", nplay, 1);
        press(1, 600);
        idle(100);
        chk(nplay == 2, "R8 busy forces retrigger", nplay, 2);
        start_test(2000, 2'd0, 1, 0);
        press(1, 20); idle(100); press(1, 600); idle(100);
        chk(nplay == 1, "R8 keep bit set ignores busy", nplay, 1);

        // Looping
        start_test(100, 2'd0, 1, 0);
        set_cfg(4, mk(1, 0, 0, 0, 1, 1));
        press(4, 20);
        idle(500);
        chk(nplay >= 4 && nstop == 0, "R9 unhold loop repeats", nplay, 4);
        start_test(100, 2'd0, 1, 0);
        set_cfg(3, mk(1, 1, 0, 0, 1, 1));
        press(3, 350);
        idle(20);
        snap = nplay;
        chk(snap >= 3, "R9 hold loop repeats while held", snap, 3);
        idle(500);
        chk(nplay == snap && nstop == 1, "R9 hold loop stops at release", nplay, snap);

        // Fixed single-key slot
        start_test(50, 2'd0, 1, 0);
        sent_map[4:0] = 5'd17;
        press(0, 12);
        idle(100);
        chk(nplay == 1 && hist[0] == 17, "R10 fixed mode slot 0", hist[0], 17);

        // Play-next sweep
        for (int cnt = 1; cnt <= 32; cnt++) begin
            start_test(10, 2'd2, cnt, 0);
            for (int p = 0; p <= cnt; p++) begin
                press(0, 12);
                idle(40);
                chk(nplay == p + 1 && hist[p] == p % cnt, "R11 play-next index", hist[p], p % cnt);
            end
        end

        // Play-all sweep
        for (int cnt = 1; cnt <= 8; cnt++) begin
            start_test(20, 2'd1, cnt, 0);
            press(0, 12);
            idle(300);
            chk(nplay == cnt, "R12 play-all count", nplay, cnt);
            for (int j = 0; j < cnt; j++)
                chk(hist[j] == j, "R12 play-all order", hist[j], j);
        end

        // Random sweep
        for (int cnt = 1; cnt <= 32; cnt++) begin
            start_test(10, 2'd3, cnt, 0);
            l = 8'd1;
            for (int p = 0; p < 4; p++) begin
                press(0, 12);
                idle(40);
                chk(nplay == p + 1 && hist[p] == int'(l) % cnt, "R13 random index", hist[p], int'(l) % cnt);
                l = lstep(l);
            end
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule